// File: doc/BRIEF.md
# Shared Debug Register File with Ownership Gating and Request Recorder

This block keeps a handful of debug control, status and value registers that two agents share. A software port serves the core's special-register moves. An external debug port, used by a hardware debugger, always has full read and write access. A mode register holds two enables, an internal-debug enable and an external-debug enable. While the external-debug enable is set, a per-resource ownership mask decides which fields software may still change. Software writes to fields it does not own are dropped without any error. Software reads of such fields are flagged as not guaranteed.

The block also watches an asynchronous debug-request line. It passes the line through a two-flop synchronizer and detects the rising edge. On that edge it sets a sticky status flag, provided that either debug enable is set. This event has no enable bit of its own, and it takes no interrupt-enable into account.

Top module: `dbg_own_regs`

## Requirements
- R1: A rising transition of `dbg_req_i` is synchronized through two flops and edge-detected. If `dbg_req_i` goes high before rising edge N, the status flag reads 1 after edge N+2. A level held high does not set the flag again once it has been cleared.
- R2: The request is recorded only when the internal-debug enable (mode bit 0) or the external-debug enable (mode bit 1) is 1. When both are 0, the edge is lost.
- R3: The status register is at address 2, and the flag is bit 0. Writing a 1 to bit 0 clears the flag. Software can clear it only when the ownership rules allow it. If a new request edge arrives in the same cycle as a clear, the flag stays 1.
- R4: The mode register is at address 0. Software can change only bit 0. Bit 1 (external-debug enable) is written only by the debug port.
- R5: While mode bit 1 is 1, a software write to a resource whose ownership bit is 0 is discarded. While mode bit 1 is 0, software may write every resource.
- R6: The ownership mask is at address 1, and only the debug port can write it. Bit 0 covers mode bit 0, bit 1 covers the status flag, and bit 2+k covers value register k.
- R7: The value registers are at addresses 3 to 3+NUM_VAL-1. The debug port writes and reads every register and field. Read data is combinational from the current register state.
- R8: `sw_rd_unsure_o` is 1 when mode bit 1 is 1 and `sw_addr_i` selects the status flag or a value register whose ownership bit is 0. It is 0 in every other case, and always 0 for addresses 0 and 1.
- R9: When both ports write the same address in one cycle, the debug port's data is applied and the software write is dropped.
- R10: Reset clears the mode bits, the ownership mask, the status flag, the value registers and the synchronizer history.
- R11: Addresses outside the map read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| dbg_req_i | input | 1 | Asynchronous debug-request line |
| sw_we_i | input | 1 | Software write strobe |
| sw_addr_i | input | ADDR_W | Software register address |
| sw_wdata_i | input | DATA_W | Software write data |
| sw_rdata_o | output | DATA_W | Software read data |
| sw_rd_unsure_o | output | 1 | Software read value not guaranteed |
| hw_we_i | input | 1 | Debug-port write strobe |
| hw_addr_i | input | ADDR_W | Debug-port register address |
| hw_wdata_i | input | DATA_W | Debug-port write data |
| hw_rdata_o | output | DATA_W | Debug-port read data |

## Verification
Read data and the unsure flag depend only on the current state and the addresses, so they are due in the same cycle. A write shows up after one rising edge. A request edge shows up in the status flag after the third rising edge that follows the change on `dbg_req_i`. The bench drives its inputs and samples at the falling edge. Its behavioural model advances one step per rising edge, so every comparison falls in the cycle in which each result is due. Directed checks test the status flag exactly one cycle before and in the cycle it is due.

// File: rtl/dbg_own_pkg.sv
package dbg_own_pkg;
    localparam int A_MODE = 0;
    localparam int A_OWN  = 1;
    localparam int A_STAT = 2;
    localparam int A_VAL0 = 3;
    localparam int RES_MODE = 0;
    localparam int RES_STAT = 1;
    localparam int RES_VAL0 = 2;
endpackage

// File: rtl/dbg_req_detect.sv
module dbg_req_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    output logic rise_o
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic prev;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d      = sync_q;
        sync_d.s1   = req_i;
        sync_d.s2   = sync_q.s1;
        sync_d.prev = sync_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign rise_o = sync_q.s2 & ~sync_q.prev;

    // R1: one level change gives exactly one pulse
    p_rise_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
endmodule

// File: rtl/dbg_sw_gate.sv
module dbg_sw_gate
    import dbg_own_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int NUM_VAL = 4,
    localparam int NUM_RES = RES_VAL0 + NUM_VAL,
    localparam int IDX_W   = $clog2(NUM_RES)
) (
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic               ext_mode_i,
    input  logic [NUM_RES-1:0] own_i,
    output logic               wr_ok_o,
    output logic               rd_unsure_o
);
    logic             res_valid;
    logic [IDX_W-1:0] res_idx;

    always_comb begin
        res_valid = 1'b0;
        res_idx   = '0;
        if (addr_i == ADDR_W'(A_MODE)) begin
            res_valid = 1'b1;
            res_idx   = IDX_W'(RES_MODE);
        end else if (addr_i == ADDR_W'(A_STAT)) begin
            res_valid = 1'b1;
            res_idx   = IDX_W'(RES_STAT);
        end
        for (int k = 0; k < NUM_VAL; k++) begin
            if (addr_i == ADDR_W'(A_VAL0 + k)) begin
                res_valid = 1'b1;
                res_idx   = IDX_W'(RES_VAL0 + k);
            end
        end
    end

    assign wr_ok_o     = res_valid & (~ext_mode_i | own_i[res_idx]);
    assign rd_unsure_o = res_valid & ext_mode_i & ~own_i[res_idx]
                         & (addr_i != ADDR_W'(A_MODE));
endmodule

// File: rtl/dbg_own_regs.sv
module dbg_own_regs
    import dbg_own_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int NUM_VAL = 4,
    parameter int ADDR_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dbg_req_i,
    input  logic              sw_we_i,
    input  logic [ADDR_W-1:0] sw_addr_i,
    input  logic [DATA_W-1:0] sw_wdata_i,
    output logic [DATA_W-1:0] sw_rdata_o,
    output logic              sw_rd_unsure_o,
    input  logic              hw_we_i,
    input  logic [ADDR_W-1:0] hw_addr_i,
    input  logic [DATA_W-1:0] hw_wdata_i,
    output logic [DATA_W-1:0] hw_rdata_o
);
    localparam int NUM_RES = RES_VAL0 + NUM_VAL;

    initial begin
        assert (A_VAL0 + NUM_VAL <= (1 << ADDR_W));
        assert (DATA_W >= NUM_RES);
    end

    typedef struct packed {
        logic                           int_mode;
        logic                           ext_mode;
        logic [NUM_RES-1:0]             own;
        logic                           stat;
        logic [NUM_VAL-1:0][DATA_W-1:0] val;
    } regs_t;

    regs_t regs_d, regs_q;
    logic  req_rise;
    logic  sw_ok;

    dbg_req_detect i_detect (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_i  (dbg_req_i),
        .rise_o (req_rise)
    );

    dbg_sw_gate #(.ADDR_W(ADDR_W), .NUM_VAL(NUM_VAL)) i_gate (
        .addr_i      (sw_addr_i),
        .ext_mode_i  (regs_q.ext_mode),
        .own_i       (regs_q.own),
        .wr_ok_o     (sw_ok),
        .rd_unsure_o (sw_rd_unsure_o)
    );

    function automatic logic [DATA_W-1:0] rd_mux(input logic [ADDR_W-1:0] a,
                                                 input regs_t s);
        logic [DATA_W-1:0] r;
        r = '0;
        if (a == ADDR_W'(A_MODE)) begin
            r[0] = s.int_mode;
            r[1] = s.ext_mode;
        end else if (a == ADDR_W'(A_OWN)) begin
            r[NUM_RES-1:0] = s.own;
        end else if (a == ADDR_W'(A_STAT)) begin
            r[0] = s.stat;
        end
        for (int k = 0; k < NUM_VAL; k++)
            if (a == ADDR_W'(A_VAL0 + k)) r = s.val[k];
        return r;
    endfunction

    logic hw_hit_stat, sw_clr, hw_clr;

    always_comb begin
        regs_d = regs_q;
        // mode: the debug port takes precedence over software
        if (hw_we_i && hw_addr_i == ADDR_W'(A_MODE)) begin
            regs_d.int_mode = hw_wdata_i[0];
            regs_d.ext_mode = hw_wdata_i[1];
        end else if (sw_we_i && sw_ok && sw_addr_i == ADDR_W'(A_MODE)) begin
            regs_d.int_mode = sw_wdata_i[0];
        end
        // ownership mask is written from the debug port only
        if (hw_we_i && hw_addr_i == ADDR_W'(A_OWN))
            regs_d.own = hw_wdata_i[NUM_RES-1:0];
        // status flag: write-one-to-clear, a new edge wins
        hw_hit_stat = hw_we_i && hw_addr_i == ADDR_W'(A_STAT);
        hw_clr      = hw_hit_stat && hw_wdata_i[0];
        sw_clr      = sw_we_i && sw_ok && !hw_hit_stat
                      && sw_addr_i == ADDR_W'(A_STAT) && sw_wdata_i[0];
        regs_d.stat = (regs_q.stat & ~(hw_clr | sw_clr))
                      | (req_rise & (regs_q.int_mode | regs_q.ext_mode));
        for (int k = 0; k < NUM_VAL; k++) begin
            if (hw_we_i && hw_addr_i == ADDR_W'(A_VAL0 + k))
                regs_d.val[k] = hw_wdata_i;
            else if (sw_we_i && sw_ok && sw_addr_i == ADDR_W'(A_VAL0 + k))
                regs_d.val[k] = sw_wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign sw_rdata_o = rd_mux(sw_addr_i, regs_q);
    assign hw_rdata_o = rd_mux(hw_addr_i, regs_q);

    // R2: the flag only rises while one of the enables was set
    p_rec_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(regs_q.stat) |-> $past(regs_q.int_mode | regs_q.ext_mode));
    // R3: an edge in the same cycle as a clear leaves the flag set
    p_evt_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_rise && (regs_q.int_mode || regs_q.ext_mode)) |=> regs_q.stat);
    // R5: an unowned value register does not move on a software write
    p_sw_blocked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_we_i && sw_addr_i == ADDR_W'(A_VAL0) && regs_q.ext_mode
         && !regs_q.own[RES_VAL0]
         && !(hw_we_i && hw_addr_i == ADDR_W'(A_VAL0)))
        |=> $stable(regs_q.val[0]));
    // R6: the mask changes only through the debug port
    p_own_hw_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(hw_we_i && hw_addr_i == ADDR_W'(A_OWN)) |=> $stable(regs_q.own));
    // R9: on a collision the debug port's data lands
    p_hw_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_we_i && sw_we_i && hw_addr_i == sw_addr_i
         && hw_addr_i == ADDR_W'(A_VAL0))
        |=> regs_q.val[0] == $past(hw_wdata_i));
endmodule

// File: tb/test_dbg_own_regs.sv
`timescale 1ns/1ps
module test_dbg_own_regs;
    localparam int DW = 32;
    localparam int NV = 4;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req = 1'b0;
    logic          sw_we = 1'b0, hw_we = 1'b0;
    logic [AW-1:0] sw_a = '0, hw_a = '0;
    logic [DW-1:0] sw_d = '0, hw_d = '0;
    logic [DW-1:0] sw_rd, hw_rd;
    logic          unsure;

    int checks = 0, fails = 0;
    bit done = 0;

    always #5 clk = ~clk;

    dbg_own_regs #(.DATA_W(DW), .NUM_VAL(NV), .ADDR_W(AW)) i_dbg_own_regs (
        .clk(clk), .rst_n(rst_n), .dbg_req_i(req),
        .sw_we_i(sw_we), .sw_addr_i(sw_a), .sw_wdata_i(sw_d),
        .sw_rdata_o(sw_rd), .sw_rd_unsure_o(unsure),
        .hw_we_i(hw_we), .hw_addr_i(hw_a), .hw_wdata_i(hw_d),
        .hw_rdata_o(hw_rd));

    // behavioural model
    bit          m_int, m_ext, m_stat;
    bit [5:0]    m_own;
    bit [DW-1:0] m_val [NV];
    bit          m_s1, m_s2, m_prv;

    function automatic int res_of(input int a);
        if (a == 0) return 0;
        if (a == 2) return 1;
        if (a >= 3 && a < 3 + NV) return a - 1;
        return -1;
    endfunction

    function automatic bit [DW-1:0] m_read(input int a);
        if (a == 0) return {30'd0, m_ext, m_int};
        if (a == 1) return {26'd0, m_own};
        if (a == 2) return {31'd0, m_stat};
        if (a >= 3 && a < 3 + NV) return m_val[a-3];
        return '0;
    endfunction

    function automatic bit m_unsure(input int a);
        int r = res_of(a);
        return (r > 0) && m_ext && !m_own[r];
    endfunction

    function automatic string tag_of(input int a);
        if (a == 0) return "R4";
        if (a == 1) return "R6";
        if (a == 2) return "R3";
        if (a >= 3 && a < 3 + NV) return "R7";
        return "R11";
    endfunction

    task automatic m_reset();
        m_int = 0; m_ext = 0; m_stat = 0; m_own = '0;
        m_s1 = 0; m_s2 = 0; m_prv = 0;
        for (int k = 0; k < NV; k++) m_val[k] = '0;
    endtask

    task automatic m_clock();
        bit edge_now, sw_ok, hw_stat, n_int, n_ext, n_stat;
        bit [5:0] n_own;
        int r;
        edge_now = m_s2 && !m_prv;
        r = res_of(int'(sw_a));
        sw_ok = (r >= 0) && (!m_ext || m_own[r]);
        n_int = m_int; n_ext = m_ext; n_own = m_own;
        if (hw_we && hw_a == 0) begin n_int = hw_d[0]; n_ext = hw_d[1]; end
        else if (sw_we && sw_ok && sw_a == 0) n_int = sw_d[0];
        if (hw_we && hw_a == 1) n_own = hw_d[5:0];
        hw_stat = hw_we && hw_a == 2;
        n_stat = m_stat;
        if (hw_stat && hw_d[0]) n_stat = 0;
        if (!hw_stat && sw_we && sw_ok && sw_a == 2 && sw_d[0]) n_stat = 0;
        if (edge_now && (m_int || m_ext)) n_stat = 1;
        for (int k = 0; k < NV; k++) begin
            if (hw_we && hw_a == AW'(3 + k)) m_val[k] = hw_d;
            else if (sw_we && sw_ok && sw_a == AW'(3 + k)) m_val[k] = sw_d;
        end
        m_int = n_int; m_ext = n_ext; m_own = n_own; m_stat = n_stat;
        m_prv = m_s2; m_s2 = m_s1; m_s1 = req;
    endtask

    task automatic chk(input string tag, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare();
        chk({tag_of(int'(hw_a)), " hw read"}, hw_rd, m_read(int'(hw_a)));
        chk({tag_of(int'(sw_a)), " sw read"}, sw_rd, m_read(int'(sw_a)));
        chk("R8 unsure", {31'd0, unsure}, {31'd0, m_unsure(int'(sw_a))});
    endtask

    // one clock: inputs already set at falling edge
    task automatic step(input bit swe, input int sa, input logic [DW-1:0] sd,
                        input bit hwe, input int ha, input logic [DW-1:0] hd,
                        input bit rq);
        sw_we = swe; sw_a = AW'(sa); sw_d = sd;
        hw_we = hwe; hw_a = AW'(ha); hw_d = hd; req = rq;
        @(posedge clk);
        m_clock();
        @(negedge clk);
        compare();
    endtask

    task automatic idle(input int sa, input int ha, input bit rq);
        step(0, sa, '0, 0, ha, '0, rq);
    endtask

    initial begin
        #(20000 * 10);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        m_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10: everything reads zero after reset
        for (int a = 0; a < 3 + NV; a++) begin
            idle(a, a, 0);
            chk("R10 reset", hw_rd, '0);
        end
        // R2: edge with both enables clear is lost
        for (int i = 0; i < 4; i++) idle(2, 2, 1);
        for (int i = 0; i < 3; i++) idle(2, 2, 0);
        chk("R2 no record", hw_rd, '0);
        // R4/R5: software sets internal enable; ext bit ignored from software
        step(1, 0, 32'h3, 0, 0, '0, 0);
        chk("R4 sw mode", hw_rd, 32'h1);
        // R1: edge timing
        idle(2, 2, 1);
        idle(2, 2, 1);
        chk("R1 not yet", hw_rd, 32'h0);
        idle(2, 2, 1);
        chk("R1 due", hw_rd, 32'h1);
        step(1, 2, 32'h1, 0, 2, '0, 1);
        chk("R3 sw clear", hw_rd, 32'h0);
        for (int i = 0; i < 4; i++) idle(2, 2, 1);
        chk("R1 held no refire", hw_rd, 32'h0);
        // R4: debug port sets ext, clears int; mask zero
        step(0, 3, '0, 1, 0, 32'h2, 0);
        chk("R4 hw mode", hw_rd, 32'h2);
        step(1, 3, 32'hdead_beef, 0, 3, '0, 0);
        chk("R5 blocked", hw_rd, 32'h0);
        chk("R8 unowned val", {31'd0, unsure}, 32'h1);
        idle(0, 0, 0);
        chk("R8 mode consistent", {31'd0, unsure}, 32'h0);
        idle(1, 1, 0);
        chk("R8 mask consistent", {31'd0, unsure}, 32'h0);
        // R2: ext enable alone records
        idle(2, 2, 1); idle(2, 2, 1); idle(2, 2, 1);
        chk("R2 ext records", hw_rd, 32'h1);
        step(1, 2, 32'h1, 0, 2, '0, 1);
        chk("R5 sw clear blocked", hw_rd, 32'h1);
        step(0, 2, '0, 1, 2, 32'h1, 0);
        chk("R7 hw clear", hw_rd, 32'h0);
        // R3: clear in the same cycle as an edge
        idle(2, 2, 0); idle(2, 2, 0);
        idle(2, 2, 1);
        idle(2, 2, 1);
        step(0, 2, '0, 1, 2, 32'h1, 1);
        chk("R3 edge beats clear", hw_rd, 32'h1);
        // R6: software cannot write the mask
        step(1, 1, 32'h3f, 0, 1, '0, 1);
        chk("R6 sw mask", hw_rd, 32'h0);
        step(0, 3, '0, 1, 1, 32'h04, 1);
        step(1, 3, 32'h1234_5678, 0, 3, '0, 1);
        chk("R5 owned write", hw_rd, 32'h1234_5678);
        // R9: collision
        step(0, 4, '0, 1, 1, 32'h3f, 1);
        step(1, 4, 32'h1111_1111, 1, 4, 32'h2222_2222, 1);
        chk("R9 hw wins", hw_rd, 32'h2222_2222);
        // R11: outside the map
        step(1, 15, 32'hffff_ffff, 1, 15, 32'hffff_ffff, 1);
        chk("R11 out of map", hw_rd, '0);
        // mixed traffic against the model
        for (int i = 0; i < 600; i++) begin
            step(1'($urandom_range(0, 1)), $urandom_range(0, 9), $urandom,
                 1'($urandom_range(0, 3) == 0), $urandom_range(0, 9),
                 $urandom & 32'h0000_00ff ^ {24'd0, 8'($urandom)},
                 1'($urandom_range(0, 4) == 0));
        end
        // R10: reset in the middle of activity
        rst_n = 1'b0;
        m_reset();
        @(negedge clk);
        rst_n = 1'b1;
        idle(0, 1, 0);
        chk("R10 mode after reset", sw_rd, '0);
        chk("R10 mask after reset", hw_rd, '0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule